// File: doc/BRIEF.md
# Burst Completion Event Trace Buffer

This block sits beside a memory interconnect and records one typed event for every burst that any monitored master finishes. Each master raises a one-cycle completion strobe together with the parameters of the finished request: its data width in bits, its burst length in data words, the number of bursts in the request and the byte count. The block stamps the event with a free-running cycle counter, tags it with the master index and the event type "burst done", and pushes it into a first-word-fall-through FIFO whose depth is a parameter. A host later drains the FIFO through a pop strobe to rebuild a time-ordered picture of how the interconnect arbitrated between masters.

Capture runs only while the block is in trace mode. In profile mode no events are taken. A freeze command from the host stops all further writes into the FIFO so that its contents can be read out undisturbed. The block observes traffic and never holds it back: a full FIFO, or a master that completes again before its previous event left staging, loses the event and raises a sticky overflow flag.

Top module: `burst_trace_buf`

## Requirements
- R1: After reset the FIFO is empty (rd_empty = 1, rd_count = 0) and overflow = 0.
- R2: In trace mode (trace_mode = 1), a completion strobe on one master sampled at clock edge k produces exactly one record, readable after edge k+1 and not before, with rd_type = 1 (burst done).
- R3: A record carries the index of the completing master in rd_mst and copies that master's data width, burst length, burst count and byte count, as sampled at the completion edge.
- R4: rd_ts holds the value of a cycle counter that is 0 in the first cycle after reset and adds 1 at every clock edge, taken in the completion cycle.
- R5: Completions from several masters in one cycle are written one per cycle in ascending master index on consecutive edges, all carrying the same timestamp.
- R6: While trace_mode = 0, completion strobes produce no records.
- R7: A one-cycle freeze_req blocks every FIFO write from that cycle until reset and discards events still in staging; popping keeps working.
- R8: When the FIFO holds DEPTH records, new records are dropped, stored records are kept in order, and overflow becomes 1 and stays 1 until reset.
- R9: A master that completes again while its earlier event still waits in staging loses the new event and sets overflow; the waiting event is written unchanged.
- R10: rd_count equals the number of stored records; rd_pop while empty has no effect; records leave in write order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_mode | input | 1 | 1 = trace (capture events), 0 = profile (no events) |
| freeze_req | input | 1 | Pulse: stop all FIFO writes until reset |
| mst_done | input | NM | Per-master burst completion strobe |
| mst_dwidth | input | NM x DW_W | Per-master data width in bits |
| mst_len | input | NM x LEN_W | Per-master burst length in data words |
| mst_nburst | input | NM x NB_W | Per-master number of bursts in the request |
| mst_bytes | input | NM x BYTES_W | Per-master bytes in the request |
| rd_pop | input | 1 | Remove the head record |
| rd_empty | output | 1 | No record available |
| rd_count | output | clog2(DEPTH+1) | Number of stored records |
| rd_ts | output | TS_W | Head record timestamp |
| rd_type | output | 2 | Head record event type (1 = burst done) |
| rd_mst | output | max(1,clog2(NM)) | Head record master index |
| rd_dwidth | output | DW_W | Head record data width |
| rd_len | output | LEN_W | Head record burst length |
| rd_nburst | output | NB_W | Head record burst count |
| rd_bytes | output | BYTES_W | Head record byte count |
| overflow | output | 1 | Sticky: at least one event was lost |

## Verification
The two functions that collide in one cycle are event staging and the hand-off into the FIFO: a master can complete again in the very cycle its earlier event waits behind a lower-numbered master. The bench provokes this by strobing masters 0 and 3 together and then master 3 alone on the next cycle, and judges it by a raised overflow, exactly two records in the FIFO and the original timestamp on master 3's record. A second collision, freeze arriving in the cycle a staged event would be written, is provoked directly and judged by an unchanged record count.

// File: rtl/btrace_pkg.sv
package btrace_pkg;

    typedef enum logic [1:0] {
        EV_NONE       = 2'd0,
        EV_BURST_DONE = 2'd1
    } bt_evt_e;

    // width needed to index n items, never below 1
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // width needed to hold a count of 0..n
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bt_tstamp.sv
module bt_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] ts
);

    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + 1'b1;
    end

    assign ts = ts_q;

    // R4: counter advances by exactly one per edge
    p_ts_step_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ts_q == $past(ts_q) + 1'b1);

endmodule

// File: rtl/bt_stage.sv
module bt_stage import btrace_pkg::*; #(
    parameter int NM    = 4,
    parameter int REC_W = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NM-1:0]              load,
    input  logic [NM-1:0][REC_W-1:0]   rec_in,
    input  logic                       flush,
    output logic                       sel_vld,
    output logic [REC_W-1:0]           sel_rec,
    output logic                       drop
);

    localparam int IW = idx_w(NM);

    logic [NM-1:0]            pend_q;
    logic [NM-1:0][REC_W-1:0] slot_q;
    logic [NM-1:0]            grant;
    logic [IW-1:0]            sel_idx;

    // lowest pending index wins
    always_comb begin
        sel_vld = 1'b0;
        sel_idx = '0;
        for (int i = NM - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                sel_vld = 1'b1;
                sel_idx = IW'(i);
            end
        end
        grant = sel_vld ? (NM'(1) << sel_idx) : '0;
    end

    assign sel_rec = slot_q[sel_idx];
    assign drop    = !flush && (|(load & pend_q & ~grant));

    generate
        for (genvar i = 0; i < NM; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    pend_q[i] <= 1'b0;
                end else if (load[i]) begin
                    if (!pend_q[i] || grant[i]) begin
                        pend_q[i] <= 1'b1;
                    end
                end else if (grant[i]) begin
                    pend_q[i] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (load[i] && (!pend_q[i] || grant[i])) begin
                    slot_q[i] <= rec_in[i];
                end
            end

            // R5/R9: a slot passed over by the picker keeps its event
            p_wait_hold_r5: assert property (@(posedge clk) disable iff (rst)
                (pend_q[i] && !grant[i] && !flush) |=>
                    (pend_q[i] && slot_q[i] == $past(slot_q[i])));

            // R7: flush leaves nothing staged
            p_flush_clear_r7: assert property (@(posedge clk) disable iff (rst)
                flush |=> !pend_q[i]);
        end
    endgenerate

endmodule

// File: rtl/bt_fifo.sv
module bt_fifo import btrace_pkg::*; #(
    parameter int W     = 64,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_req,
    input  logic [W-1:0]              wr_data,
    input  logic                      rd_pop,
    output logic [W-1:0]              rd_data,
    output logic                      empty,
    output logic [cnt_w(DEPTH)-1:0]   count,
    output logic                      wr_drop
);

    localparam int AW = idx_w(DEPTH);
    localparam int CW = cnt_w(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, wr_ok, rd_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign wr_ok   = wr_req && !full;
    assign rd_ok   = rd_pop && !empty;
    assign wr_drop = wr_req && full;
    assign rd_data = mem[rp_q];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) wp_q <= nxt(wp_q);
            if (rd_ok) rp_q <= nxt(rp_q);
            case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp_q] <= wr_data;
    end

    // R10: occupancy bounded by depth
    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R10: a lone pop removes one record
    p_pop_dec_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !empty && !wr_req) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R8: a write into a full FIFO adds nothing
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && !rd_pop) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/burst_trace_buf.sv
module burst_trace_buf import btrace_pkg::*; #(
    parameter int NM      = 4,
    parameter int DEPTH   = 16,
    parameter int TS_W    = 32,
    parameter int DW_W    = 11,
    parameter int LEN_W   = 9,
    parameter int NB_W    = 8,
    parameter int BYTES_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          trace_mode,
    input  logic                          freeze_req,
    input  logic [NM-1:0]                 mst_done,
    input  logic [NM-1:0][DW_W-1:0]       mst_dwidth,
    input  logic [NM-1:0][LEN_W-1:0]      mst_len,
    input  logic [NM-1:0][NB_W-1:0]       mst_nburst,
    input  logic [NM-1:0][BYTES_W-1:0]    mst_bytes,
    input  logic                          rd_pop,
    output logic                          rd_empty,
    output logic [cnt_w(DEPTH)-1:0]       rd_count,
    output logic [TS_W-1:0]               rd_ts,
    output logic [1:0]                    rd_type,
    output logic [idx_w(NM)-1:0]          rd_mst,
    output logic [DW_W-1:0]               rd_dwidth,
    output logic [LEN_W-1:0]              rd_len,
    output logic [NB_W-1:0]               rd_nburst,
    output logic [BYTES_W-1:0]            rd_bytes,
    output logic                          overflow
);

    localparam int IW = idx_w(NM);

    typedef struct packed {
        logic [TS_W-1:0]    ts;
        bt_evt_e            etype;
        logic [IW-1:0]      mst;
        logic [DW_W-1:0]    dwidth;
        logic [LEN_W-1:0]   len;
        logic [NB_W-1:0]    nburst;
        logic [BYTES_W-1:0] bytes;
    } bt_rec_t;

    localparam int REC_W = $bits(bt_rec_t);

    logic [TS_W-1:0]    ts_now;
    logic               frozen_q;
    logic               capture_en;
    logic [NM-1:0]      load;
    bt_rec_t [NM-1:0]   recs;
    logic               sel_vld;
    logic [REC_W-1:0]   sel_rec;
    logic               stage_drop;
    logic               fifo_wr;
    logic               fifo_drop;
    logic [REC_W-1:0]   head_bits;
    bt_rec_t            head;
    logic               ovf_q;

    bt_tstamp #(.TS_W(TS_W)) u_ts (
        .clk (clk),
        .rst (rst),
        .ts  (ts_now)
    );

    always_ff @(posedge clk) begin
        if (rst)             frozen_q <= 1'b0;
        else if (freeze_req) frozen_q <= 1'b1;
    end

    assign capture_en = trace_mode && !frozen_q && !freeze_req;
    assign load       = mst_done & {NM{capture_en}};

    generate
        for (genvar i = 0; i < NM; i++) begin : g_rec
            assign recs[i] = '{
                ts:     ts_now,
                etype:  EV_BURST_DONE,
                mst:    IW'(i),
                dwidth: mst_dwidth[i],
                len:    mst_len[i],
                nburst: mst_nburst[i],
                bytes:  mst_bytes[i]
            };
        end
    endgenerate

    bt_stage #(.NM(NM), .REC_W(REC_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .rec_in  (recs),
        .flush   (freeze_req),
        .sel_vld (sel_vld),
        .sel_rec (sel_rec),
        .drop    (stage_drop)
    );

    assign fifo_wr = sel_vld && !frozen_q && !freeze_req;

    bt_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (fifo_wr),
        .wr_data (sel_rec),
        .rd_pop  (rd_pop),
        .rd_data (head_bits),
        .empty   (rd_empty),
        .count   (rd_count),
        .wr_drop (fifo_drop)
    );

    always_ff @(posedge clk) begin
        if (rst)                          ovf_q <= 1'b0;
        else if (stage_drop || fifo_drop) ovf_q <= 1'b1;
    end

    assign head      = bt_rec_t'(head_bits);
    assign rd_ts     = head.ts;
    assign rd_type   = head.etype;
    assign rd_mst    = head.mst;
    assign rd_dwidth = head.dwidth;
    assign rd_len    = head.len;
    assign rd_nburst = head.nburst;
    assign rd_bytes  = head.bytes;
    assign overflow  = ovf_q;

    // R7: once frozen, the FIFO never receives a write
    p_frozen_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        frozen_q |-> !fifo_wr);

    // R8: overflow flag is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    // R6: profile mode stages nothing new
    p_profile_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!trace_mode && !sel_vld) |=> !sel_vld);

    // R2: a write always makes the FIFO non-empty
    p_write_shows_r2: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !rd_pop) |=> !rd_empty);

endmodule

// File: tb/sim_burst_trace_buf.sv
module sim_burst_trace_buf;
    localparam int NM = 4, DEPTH = 8, TS_W = 32, DW_W = 11, LEN_W = 9, NB_W = 8, BYTES_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trace_mode = 1'b0, freeze_req = 1'b0, rd_pop = 1'b0;
    logic [NM-1:0] mst_done = '0;
    logic [NM-1:0][DW_W-1:0] mst_dwidth = '0;
    logic [NM-1:0][LEN_W-1:0] mst_len = '0;
    logic [NM-1:0][NB_W-1:0] mst_nburst = '0;
    logic [NM-1:0][BYTES_W-1:0] mst_bytes = '0;
    logic rd_empty, overflow;
    logic [3:0] rd_count;
    logic [TS_W-1:0] rd_ts;
    logic [1:0] rd_type, rd_mst;
    logic [DW_W-1:0] rd_dwidth;
    logic [LEN_W-1:0] rd_len;
    logic [NB_W-1:0] rd_nburst;
    logic [BYTES_W-1:0] rd_bytes;

    int checks = 0, errors = 0;
    logic [31:0] bcyc;
    bit finished = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) bcyc <= '0;
        else     bcyc <= bcyc + 1;
    end

    burst_trace_buf #(.NM(NM), .DEPTH(DEPTH), .TS_W(TS_W), .DW_W(DW_W), .LEN_W(LEN_W),
                      .NB_W(NB_W), .BYTES_W(BYTES_W)) u0 (
        .clk(clk), .rst(rst), .trace_mode(trace_mode), .freeze_req(freeze_req),
        .mst_done(mst_done), .mst_dwidth(mst_dwidth), .mst_len(mst_len),
        .mst_nburst(mst_nburst), .mst_bytes(mst_bytes), .rd_pop(rd_pop),
        .rd_empty(rd_empty), .rd_count(rd_count), .rd_ts(rd_ts), .rd_type(rd_type),
        .rd_mst(rd_mst), .rd_dwidth(rd_dwidth), .rd_len(rd_len), .rd_nburst(rd_nburst),
        .rd_bytes(rd_bytes), .overflow(overflow)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; trace_mode = 1'b0; freeze_req = 1'b0; rd_pop = 1'b0; mst_done = '0;
        repeat (3) step();
        rst = 1'b0;
    endtask

    // master parameters derived from index and a salt
    task automatic set_params(input int salt);
        for (int i = 0; i < NM; i++) begin
            mst_dwidth[i] = DW_W'(8 << i);
            mst_len[i]    = LEN_W'(salt + i);
            mst_nburst[i] = NB_W'(salt % 7 + i + 1);
            mst_bytes[i]  = BYTES_W'(salt * 13 + i * 101);
        end
    endtask

    task automatic check_head(input string req, input int m, input int salt, input logic [31:0] ts);
        check(req, "empty", rd_empty, 0);
        check(req, "type", rd_type, 1);
        check(req, "mst", rd_mst, m);
        check(req, "dwidth", rd_dwidth, DW_W'(8 << m));
        check(req, "len", rd_len, LEN_W'(salt + m));
        check(req, "nburst", rd_nburst, NB_W'(salt % 7 + m + 1));
        check(req, "bytes", rd_bytes, BYTES_W'(salt * 13 + m * 101));
        check(req, "ts", rd_ts, ts);
    endtask

    task automatic pop();
        rd_pop = 1'b1; step(); rd_pop = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "empty", rd_empty, 1);
        check("R1", "count", rd_count, 0);
        check("R1", "overflow", overflow, 0);
    endtask

    task automatic t_single();
        logic [31:0] t0;
        do_reset();
        trace_mode = 1'b1; set_params(20);
        repeat (2) step();
        t0 = bcyc;
        mst_done = 4'b0100; step(); mst_done = '0;
        check("R2", "empty one edge after done", rd_empty, 1);
        step();
        check("R2", "count", rd_count, 1);
        check_head("R3", 2, 20, t0);
        check("R4", "ts since reset", t0, 2);
        set_params(55); step();
        check("R3", "fields fixed at completion", rd_len, LEN_W'(22));
        pop();
        check("R10", "empty after pop", rd_empty, 1);
    endtask

    task automatic t_simul();
        logic [31:0] t0;
        do_reset();
        trace_mode = 1'b1; set_params(9); step();
        t0 = bcyc;
        mst_done = 4'b1011; step(); mst_done = '0;
        step(); check("R5", "count after 1st edge", rd_count, 1);
        step(); check("R5", "count after 2nd edge", rd_count, 2);
        step(); check("R5", "count after 3rd edge", rd_count, 3);
        check_head("R5", 0, 9, t0); pop();
        check_head("R5", 1, 9, t0); pop();
        check_head("R5", 3, 9, t0); pop();
        check("R10", "drained", rd_count, 0);
        check("R5", "no overflow", overflow, 0);
    endtask

    task automatic t_profile();
        do_reset();
        trace_mode = 1'b0; set_params(3);
        mst_done = 4'b1111; step(); mst_done = 4'b0010; step(); mst_done = '0;
        repeat (4) step();
        check("R6", "empty in profile", rd_empty, 1);
        check("R6", "count in profile", rd_count, 0);
    endtask

    task automatic t_pop_empty();
        do_reset();
        pop(); step();
        check("R10", "pop on empty count", rd_count, 0);
        check("R10", "pop on empty flag", rd_empty, 1);
        trace_mode = 1'b1; set_params(4);
        mst_done = 4'b0001; step(); mst_done = '0; step();
        check("R10", "count after write", rd_count, 1);
    endtask

    task automatic t_full();
        logic [31:0] t0;
        do_reset();
        trace_mode = 1'b1; set_params(30); step();
        t0 = bcyc;
        mst_done = 4'b0010;
        repeat (10) step();
        mst_done = '0;
        repeat (3) step();
        check("R8", "count at full", rd_count, DEPTH);
        check("R8", "overflow", overflow, 1);
        for (int k = 0; k < DEPTH; k++) begin
            check("R8", "kept order ts", rd_ts, t0 + k);
            check("R10", "count while draining", rd_count, DEPTH - k);
            pop();
        end
        check("R10", "empty after drain", rd_empty, 1);
        check("R8", "overflow sticky", overflow, 1);
    endtask

    task automatic t_stage_drop();
        logic [31:0] t0;
        do_reset();
        trace_mode = 1'b1; set_params(12); step();
        t0 = bcyc;
        mst_done = 4'b1001; step();
        set_params(77);
        mst_done = 4'b1000; step(); mst_done = '0;
        check("R9", "overflow on staged repeat", overflow, 1);
        repeat (3) step();
        check("R9", "count", rd_count, 2);
        check_head("R9", 0, 12, t0); pop();
        check_head("R9", 3, 12, t0); pop();
        check("R9", "empty", rd_empty, 1);
    endtask

    task automatic t_freeze();
        do_reset();
        trace_mode = 1'b1; set_params(5);
        mst_done = 4'b0100; step(); mst_done = '0; step();
        check("R7", "pre-freeze count", rd_count, 1);
        mst_done = 4'b0001; step(); mst_done = '0;
        freeze_req = 1'b1; step(); freeze_req = 1'b0;
        check("R7", "staged event not written", rd_count, 1);
        mst_done = 4'b1111; step(); mst_done = 4'b0010; step(); mst_done = '0;
        repeat (4) step();
        check("R7", "frozen count", rd_count, 1);
        check("R7", "frozen head", rd_mst, 2);
        pop();
        check("R7", "pop while frozen", rd_empty, 1);
        check("R7", "no overflow", overflow, 0);
    endtask

    initial begin
        step();
        t_reset();
        t_single();
        t_simul();
        t_profile();
        t_pop_empty();
        t_full();
        t_stage_drop();
        t_freeze();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule